// File: doc/BRIEF.md
# Daisy-Chain Address Assignment Node

This block is the per-module control logic for a row of modules that all sit on one shared multi-drop register bus. Each module gets its bus address from where it sits in the row. Every node leaves reset answering at a well-known default address, and only one node at a time can be out of reset while still holding that default. The host writes a unique address into that node. It then tells the node to release the reset line of its neighbour. The host repeats this until nothing answers at the default address any more.

The node takes bus requests that have already been decoded. Each request carries a target address, a register index, a write flag and write data. The node replies one cycle later, and only when the target matches its own address. Register index 0 holds the node address. Register index 1 holds the drive enable for the downstream reset line in bit 0.

The reset line between two neighbours is weakly pulled to its reset level. A node releases its neighbour by actively driving the line to the release level. In the default one-way mode, the left line is the node's reset input and the node drives only the right line. In the two-way mode, the node is held in reset only while both lines sit at the reset level. It then drives the right line when its assigned address is odd, and the left line when the address is even. This lets the row be enumerated from either end.

Top module: `chain_node`

## Requirements
- R1: While the chain reset is active (left line high in one-way mode), the node gives no response to any request. Any request made then has no effect.
- R2: After reset, the node address is 0xFF, and a read of register 0 at address 0xFF returns 0xFF.
- R3: After reset, and whenever the enable bit is 0, neither segment drive output is asserted (a 1 on a drive output means the line is actively driven to the release level; 0 means high impedance).
- R4: A write to register 0 at the matching address loads the node address from the low bits of the write data. From the next request on, only the new address gets a response.
- R5: In one-way mode, writing 1 to bit 0 of register 1 asserts the right drive output, and writing 0 clears it. The left drive output is never asserted.
- R6: When the chain reset becomes active, the enable bit clears and the address returns to 0xFF. Both drive outputs are low after the next clock edge.
- R7: A request whose target address differs from the node address gets no response and changes no register.
- R8: In two-way mode, the chain reset is the AND of the left and right line levels. With only one line high, the node runs normally.
- R9: In two-way mode, with the enable bit set, an odd address asserts only the right drive output and an even address asserts only the left drive output.
- R10: A matching request yields a response valid pulse in the cycle after it is sampled. A read returns the register value zero-extended (register 1 as the enable in bit 0). A write, or an access to any other index, returns zero data. A write to any other index changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low local reset |
| seg_l_i | input | 1 | Level of the left reset line (1 = reset) |
| seg_r_i | input | 1 | Level of the right reset line (1 = reset); used in two-way mode only |
| req_valid_i | input | 1 | Request strobe |
| req_addr_i | input | ADDR_W | Target node address |
| req_idx_i | input | IDX_W | Register index |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | DATA_W | Write data |
| rsp_valid_o | output | 1 | Response strobe, one cycle after a matching request |
| rsp_rdata_o | output | DATA_W | Response data |
| drv_l_o | output | 1 | Drive the left line to its release level |
| drv_r_o | output | 1 | Drive the right line to its release level |

## Verification
The bench renames the node and then checks that the old default address goes silent. A node that compared against a stale address would keep answering 0xFF and break enumeration. Missed writes, and writes to an unused index, must leave the drive output untouched; a design that decoded the address loosely would release its neighbour by mistake. The bench raises the chain reset while the drive is enabled, and a design that kept the enable would fail to propagate reset down the row. In two-way mode, the bench holds only one line high and then flips the address parity. A plain OR or single-line reset would freeze the node, and a swapped parity decode would release the wrong neighbour.

// File: rtl/chain_node_pkg.sv
package chain_node_pkg;
  localparam int unsigned REG_ADDR_IDX = 0;
  localparam int unsigned REG_CTRL_IDX = 1;
  localparam int unsigned CTRL_OE_BIT  = 0;
endpackage

// File: rtl/chain_node_rst.sv
module chain_node_rst #(
  parameter bit BIDIR = 1'b0
) (
  input  logic seg_l_i,
  input  logic seg_r_i,
  output logic chain_rst_o
);
  if (BIDIR) begin : g_bidir
    // weak pulls hold both lines high; either neighbour releasing frees us
    assign chain_rst_o = seg_l_i & seg_r_i;
  end else begin : g_uni
    logic unused_r;
    assign unused_r    = seg_r_i;
    assign chain_rst_o = seg_l_i;
  end
endmodule

// File: rtl/chain_node_regs.sv
module chain_node_regs
  import chain_node_pkg::*;
#(
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned IDX_W        = 2,
  parameter logic [ADDR_W-1:0] DEFAULT_ADDR = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              chain_rst_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [IDX_W-1:0]  req_idx_i,
  input  logic              req_we_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic [ADDR_W-1:0] node_addr_o,
  output logic              oe_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o
);
  localparam logic [IDX_W-1:0] IDX_ADDR = IDX_W'(REG_ADDR_IDX);
  localparam logic [IDX_W-1:0] IDX_CTRL = IDX_W'(REG_CTRL_IDX);

  logic [ADDR_W-1:0] node_addr_q;
  logic              oe_q;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_rdata_q;
  logic              hit;
  logic [DATA_W-1:0] rd_val;

  assign hit = req_valid_i && (req_addr_i == node_addr_q);

  always_comb begin
    rd_val = '0;
    case (req_idx_i)
      IDX_ADDR: rd_val = DATA_W'(node_addr_q);
      IDX_CTRL: rd_val[CTRL_OE_BIT] = oe_q;
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      node_addr_q <= DEFAULT_ADDR;
      oe_q        <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else if (chain_rst_i) begin
      node_addr_q <= DEFAULT_ADDR;
      oe_q        <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= hit;
      rsp_rdata_q <= '0;
      if (hit) begin
        if (req_we_i) begin
          if (req_idx_i == IDX_ADDR) node_addr_q <= req_wdata_i[ADDR_W-1:0];
          if (req_idx_i == IDX_CTRL) oe_q <= req_wdata_i[CTRL_OE_BIT];
        end else begin
          rsp_rdata_q <= rd_val;
        end
      end
    end
  end

  assign node_addr_o = node_addr_q;
  assign oe_o        = oe_q;
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_rdata_q;

  AST_RST_DEFAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chain_rst_i |=> (node_addr_q == DEFAULT_ADDR && !oe_q && !rsp_valid_q)); // R1
  AST_MISS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !chain_rst_i && req_addr_i != node_addr_q)
      |=> (!rsp_valid_q && $stable(node_addr_q) && $stable(oe_q))); // R7
  AST_HIT_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !chain_rst_i && req_addr_i == node_addr_q) |=> rsp_valid_q); // R10
  AST_ADDR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !chain_rst_i && req_addr_i == node_addr_q && req_we_i
      && req_idx_i == IDX_ADDR)
      |=> node_addr_q == $past(req_wdata_i[ADDR_W-1:0])); // R4
endmodule

// File: rtl/chain_node_drive.sv
module chain_node_drive #(
  parameter bit          BIDIR  = 1'b0,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              oe_i,
  input  logic [ADDR_W-1:0] node_addr_i,
  output logic              drv_l_o,
  output logic              drv_r_o
);
  if (BIDIR) begin : g_bidir
    // odd address releases the right line, even the left
    assign drv_r_o = oe_i &  node_addr_i[0];
    assign drv_l_o = oe_i & ~node_addr_i[0];
  end else begin : g_uni
    logic [ADDR_W-1:0] unused_addr;
    assign unused_addr = node_addr_i;
    assign drv_r_o = oe_i;
    assign drv_l_o = 1'b0;
    AST_UNI_LEFT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !drv_l_o); // R5
  end
endmodule

// File: rtl/chain_node.sv
module chain_node #(
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned IDX_W        = 2,
  parameter logic [ADDR_W-1:0] DEFAULT_ADDR = '1,
  parameter bit          BIDIR        = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              seg_l_i,
  input  logic              seg_r_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [IDX_W-1:0]  req_idx_i,
  input  logic              req_we_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              drv_l_o,
  output logic              drv_r_o
);
  logic              chain_rst;
  logic [ADDR_W-1:0] node_addr;
  logic              oe;

  chain_node_rst #(.BIDIR(BIDIR)) u_rst (
    .seg_l_i    (seg_l_i),
    .seg_r_i    (seg_r_i),
    .chain_rst_o(chain_rst)
  );

  chain_node_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .DEFAULT_ADDR(DEFAULT_ADDR)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .chain_rst_i(chain_rst),
    .req_valid_i(req_valid_i),
    .req_addr_i (req_addr_i),
    .req_idx_i  (req_idx_i),
    .req_we_i   (req_we_i),
    .req_wdata_i(req_wdata_i),
    .node_addr_o(node_addr),
    .oe_o       (oe),
    .rsp_valid_o(rsp_valid_o),
    .rsp_rdata_o(rsp_rdata_o)
  );

  chain_node_drive #(.BIDIR(BIDIR), .ADDR_W(ADDR_W)) u_drive (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .oe_i       (oe),
    .node_addr_i(node_addr),
    .drv_l_o    (drv_l_o),
    .drv_r_o    (drv_r_o)
  );

  AST_DRIVE_NEEDS_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe |-> !(drv_l_o || drv_r_o)); // R3
  AST_ONE_SIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({drv_l_o, drv_r_o})); // R9
  AST_RST_RELEASES_NONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chain_rst |=> !(drv_l_o || drv_r_o)); // R6
endmodule

// File: tb/sim_chain_node.sv
module sim_chain_node;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 16;

  typedef struct packed {
    logic       valid;
    logic       we;
    logic [7:0] addr;
    logic [1:0] idx;
    logic [7:0] wdata;
    logic       e_valid;
    logic [7:0] e_data;
    logic       e_drv_r;
  } vec_t;

  // valid we addr idx wdata | exp_valid exp_data exp_drv_r
  localparam logic [29:0] VECS [0:NVEC-1] = '{
    {1'b1, 1'b0, 8'hFF, 2'd0, 8'h00, 1'b1, 8'hFF, 1'b0}, // R2 read default address
    {1'b1, 1'b0, 8'hFF, 2'd1, 8'h00, 1'b1, 8'h00, 1'b0}, // R10 read enable
    {1'b1, 1'b0, 8'h01, 2'd0, 8'h00, 1'b0, 8'h00, 1'b0}, // R7 miss read
    {1'b1, 1'b1, 8'h01, 2'd0, 8'h05, 1'b0, 8'h00, 1'b0}, // R7 miss write
    {1'b1, 1'b0, 8'hFF, 2'd0, 8'h00, 1'b1, 8'hFF, 1'b0}, // R7 address held
    {1'b1, 1'b1, 8'hFF, 2'd0, 8'h03, 1'b1, 8'h00, 1'b0}, // R4 rename
    {1'b1, 1'b0, 8'hFF, 2'd0, 8'h00, 1'b0, 8'h00, 1'b0}, // R4 old address silent
    {1'b1, 1'b0, 8'h03, 2'd0, 8'h00, 1'b1, 8'h03, 1'b0}, // R4 new address
    {1'b1, 1'b1, 8'h03, 2'd1, 8'h01, 1'b1, 8'h00, 1'b1}, // R5 enable drive
    {1'b1, 1'b0, 8'h03, 2'd1, 8'h00, 1'b1, 8'h01, 1'b1}, // R10 read enable back
    {1'b0, 1'b0, 8'h03, 2'd0, 8'h00, 1'b0, 8'h00, 1'b1}, // R10 idle, no response
    {1'b1, 1'b1, 8'h03, 2'd2, 8'h55, 1'b1, 8'h00, 1'b1}, // R10 unused index write
    {1'b1, 1'b0, 8'h03, 2'd2, 8'h00, 1'b1, 8'h00, 1'b1}, // R10 unused index read
    {1'b1, 1'b1, 8'h03, 2'd1, 8'h00, 1'b1, 8'h00, 1'b0}, // R5 disable drive
    {1'b1, 1'b1, 8'h03, 2'd1, 8'h01, 1'b1, 8'h00, 1'b1}, // R5 enable again
    {1'b1, 1'b1, 8'h07, 2'd1, 8'h00, 1'b0, 8'h00, 1'b1}  // R7 miss keeps drive
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       seg0_l = 1'b0, seg0_r = 1'b0, seg1_l = 1'b1, seg1_r = 1'b1;
  logic       req_valid = 1'b0, req_we = 1'b0;
  logic [7:0] req_addr = '0, req_wdata = '0;
  logic [1:0] req_idx = '0;
  logic       rv0, rv1, dl0, dr0, dl1, dr1;
  logic [7:0] rd0, rd1;
  int         n_chk = 0, n_err = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chain_node u0 (
    .clk_i(clk), .rst_ni(rst_n), .seg_l_i(seg0_l), .seg_r_i(seg0_r),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_idx_i(req_idx),
    .req_we_i(req_we), .req_wdata_i(req_wdata),
    .rsp_valid_o(rv0), .rsp_rdata_o(rd0), .drv_l_o(dl0), .drv_r_o(dr0)
  );

  chain_node #(.BIDIR(1'b1)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .seg_l_i(seg1_l), .seg_r_i(seg1_r),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_idx_i(req_idx),
    .req_we_i(req_we), .req_wdata_i(req_wdata),
    .rsp_valid_o(rv1), .rsp_rdata_o(rd1), .drv_l_o(dl1), .drv_r_o(dr1)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge, after the sampling posedge
  task automatic req(input logic v, input logic we, input logic [7:0] a,
                     input logic [1:0] idx, input logic [7:0] wd);
    req_valid = v; req_we = we; req_addr = a; req_idx = idx; req_wdata = wd;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R3 reset u0 drv_r", {7'b0, dr0}, 8'h00);
    chk("R3 reset u0 drv_l", {7'b0, dl0}, 8'h00);
    chk("R3 reset u1 drives", {6'b0, dl1, dr1}, 8'h00);
    chk("R1 reset no response", {7'b0, rv0}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // one-way node u0; u1 parked in chain reset
    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      v = vec_t'(VECS[i]);
      req(v.valid, v.we, v.addr, v.idx, v.wdata);
      chk($sformatf("R10 vec%0d rsp_valid", i), {7'b0, rv0}, {7'b0, v.e_valid});
      if (v.e_valid) chk($sformatf("R10 vec%0d rdata", i), rd0, v.e_data);
      chk($sformatf("R5 vec%0d drv_r", i), {7'b0, dr0}, {7'b0, v.e_drv_r});
      chk($sformatf("R5 vec%0d drv_l", i), {7'b0, dl0}, 8'h00);
      chk($sformatf("R1 vec%0d u1 silent", i), {7'b0, rv1}, 8'h00);
    end

    // R6: chain reset while the drive is enabled
    seg0_l = 1'b1;
    req(1'b1, 1'b0, 8'h03, 2'd1, 8'h00);
    chk("R1 no response in reset", {7'b0, rv0}, 8'h00);
    chk("R6 drive cleared", {7'b0, dr0}, 8'h00);
    req(1'b1, 1'b1, 8'hFF, 2'd1, 8'h01);
    chk("R1 write in reset ignored rsp", {7'b0, rv0}, 8'h00);
    chk("R1 write in reset ignored drv", {7'b0, dr0}, 8'h00);
    seg0_l = 1'b0;
    req(1'b0, 1'b0, 8'h00, 2'd0, 8'h00);
    req(1'b1, 1'b0, 8'hFF, 2'd0, 8'h00);
    chk("R6 address back to default", rd0, 8'hFF);
    chk("R2 response after reset", {7'b0, rv0}, 8'h01);
    req(1'b1, 1'b0, 8'hFF, 2'd1, 8'h00);
    chk("R6 enable reads zero", rd0, 8'h00);

    // two-way node u1; u0 parked
    seg0_l = 1'b1;
    seg1_l = 1'b1; seg1_r = 1'b0;
    req(1'b1, 1'b0, 8'hFF, 2'd0, 8'h00);
    chk("R8 left-only high runs", {7'b0, rv1}, 8'h01);
    chk("R8 read default", rd1, 8'hFF);
    chk("R3 u1 no drive", {6'b0, dl1, dr1}, 8'h00);
    chk("R1 u0 parked silent", {7'b0, rv0}, 8'h00);
    req(1'b1, 1'b1, 8'hFF, 2'd1, 8'h01);
    chk("R9 odd drives right", {6'b0, dl1, dr1}, 8'h01);
    req(1'b1, 1'b1, 8'hFF, 2'd0, 8'h02);
    chk("R9 even drives left", {6'b0, dl1, dr1}, 8'h02);
    seg1_l = 1'b0; seg1_r = 1'b1;
    req(1'b1, 1'b0, 8'h02, 2'd0, 8'h00);
    chk("R8 right-only high runs", {7'b0, rv1}, 8'h01);
    chk("R4 u1 new address", rd1, 8'h02);
    seg1_l = 1'b1; seg1_r = 1'b1;
    req(1'b1, 1'b0, 8'h02, 2'd0, 8'h00);
    chk("R8 both high resets", {7'b0, rv1}, 8'h00);
    chk("R6 u1 drives cleared", {6'b0, dl1, dr1}, 8'h00);
    seg1_r = 1'b0;
    req(1'b0, 1'b0, 8'h00, 2'd0, 8'h00);
    req(1'b1, 1'b0, 8'hFF, 2'd0, 8'h00);
    chk("R6 u1 default restored", rd1, 8'hFF);

    finish_run();
  end
endmodule